// File: doc/BRIEF.md
# General-Purpose Tick Timer

This block is an up-counting timer that sits on a simple word-addressed register bus. Software chooses a tick source, sets up to two divide ratios and a compare value, enables the timer and then reads the running count back. The count is 32 bits wide by default. Each tick source arrives as a one-cycle strobe that is already in the bus clock domain. The sources are a peripheral-clock strobe, a low-frequency reference strobe near 32 kHz, and an oscillator strobe near 24 MHz. The oscillator path has its own small divider and its own gate.

The selected strobe goes through a main divider and then advances the counter. A compare register raises a sticky status flag. In restart mode the compare value also sets the counting period. In free-run mode the counter rolls over at all-ones. A self-clearing software reset bit returns every register, divider and the count to zero.

Top module: `gp_tick_timer`

## Requirements
- R1: After the reset input, every mapped register reads zero: control 0x00, divider 0x04, status 0x08, compare 0x10 and count 0x24.
- R2: While control bit 0 (enable) is 0, the count holds its value whatever strobes arrive.
- R3: Source code 001 in control bits 8:6 selects the peripheral strobe. With both dividers at 0, each strobe adds one to the count.
- R4: Source code 100 selects the reference strobe. Strobes on any other input have no effect. Every code other than 001, 100 and 101 stops counting.
- R5: Source code 101 selects the oscillator strobe, and only while control bit 10 (oscillator gate) is 1. The oscillator path divides by the value in divider bits 15:12 plus one.
- R6: Divider bits 11:0 divide the selected source by their value plus one before it reaches the count. The value 0 passes every strobe.
- R7: Status bit 0 is set when the count takes a value equal to the compare register. Writing 1 to that bit clears it. Writing 0 leaves it unchanged.
- R8: With control bit 9 at 0 (restart mode), the count returns to 0 on the first counted tick after it has equalled the compare value.
- R9: With control bit 9 at 1 (free-run mode), the count goes past the compare value and wraps from all-ones of the counter width to 0.
- R10: Writing 1 to control bit 15 clears all registers, both dividers and the count one cycle later. The bit reads back as 0 afterwards.
- R11: When the source code or a divide value changes, that divider's internal phase restarts, so its next output tick comes a full period after the write.
- R12: Read data appears on the cycle after a read strobe and shows the live count. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the word accessed |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| tick_per | input | 1 | Peripheral-clock tick strobe |
| tick_ref | input | 1 | Low-frequency reference tick strobe |
| tick_osc | input | 1 | Oscillator tick strobe |

## Verification
The bench builds the timer with an 8-bit count so that roll-over can be reached. It checks that free-run mode goes past the compare value and wraps to 0. A design that restarted on the match, or saturated at all-ones, would give a wrong count there. In restart mode the bench checks that the count returns to 0 one tick after the match and not on the match itself.

The bench changes a divide value partway through a period and counts the strobes before the next output. A divider that kept its old phase would tick too early. The bench also drives strobes on unselected sources, on a reserved code and on the oscillator while its gate is off. A selector that decoded the codes loosely would count there. Finally it checks that a software reset also clears the dividers and that the reset bit reads back as 0.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int BUS_W = 32;

    localparam logic [7:0] OFF_CTRL = 8'h00;
    localparam logic [7:0] OFF_DIV  = 8'h04;
    localparam logic [7:0] OFF_STAT = 8'h08;
    localparam logic [7:0] OFF_CMP  = 8'h10;
    localparam logic [7:0] OFF_CNT  = 8'h24;

    localparam int CB_EN    = 0;
    localparam int CB_SRC   = 6;
    localparam int CB_FREE  = 9;
    localparam int CB_OSCEN = 10;
    localparam int CB_SWR   = 15;

    typedef enum logic [2:0] {
        SRC_NONE = 3'b000,
        SRC_PER  = 3'b001,
        SRC_REF  = 3'b100,
        SRC_OSC  = 3'b101
    } src_e;

    typedef struct packed {
        logic       en;
        logic [2:0] src;
        logic       free_run;
        logic       osc_gate;
    } ctrl_t;

    function automatic ctrl_t decode_ctrl(input logic [BUS_W-1:0] w);
        ctrl_t c;
        c.en       = w[CB_EN];
        c.src      = w[CB_SRC +: 3];
        c.free_run = w[CB_FREE];
        c.osc_gate = w[CB_OSCEN];
        return c;
    endfunction

    function automatic logic [BUS_W-1:0] encode_ctrl(input ctrl_t c, input logic swr);
        logic [BUS_W-1:0] w;
        w              = '0;
        w[CB_EN]       = c.en;
        w[CB_SRC +: 3] = c.src;
        w[CB_FREE]     = c.free_run;
        w[CB_OSCEN]    = c.osc_gate;
        w[CB_SWR]      = swr;
        return w;
    endfunction

endpackage

// File: rtl/tmr_divider.sv
module tmr_divider #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         restart,
    input  logic         enable,
    input  logic         tick_in,
    input  logic [W-1:0] div,
    output logic         tick_out
);

    logic [W-1:0] phase_q;
    logic         at_end;

    assign at_end   = (phase_q == div);
    assign tick_out = enable && tick_in && at_end;

    always_ff @(posedge clk) begin
        if (rst || clr || restart) begin
            phase_q <= '0;
        end else if (enable && tick_in) begin
            phase_q <= at_end ? '0 : phase_q + 1'b1;
        end
    end

    // R6: the phase never runs past the divide value
    assert_phase_bound_R6: assert property (@(posedge clk) disable iff (rst)
        phase_q <= div);

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             cnt_en,
    input  logic             tick,
    input  logic             free_run,
    input  logic [CNT_W-1:0] cmp,
    output logic [CNT_W-1:0] count,
    output logic             match_evt
);

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] nxt;
    logic             adv;

    assign adv = cnt_en && tick;

    always_comb begin
        if (!free_run && count_q == cmp) nxt = '0;
        else                             nxt = count_q + 1'b1;
    end

    assign match_evt = adv && (nxt == cmp);
    assign count     = count_q;

    always_ff @(posedge clk) begin
        if (rst || clr) count_q <= '0;
        else if (adv)   count_q <= nxt;
    end

    assert_hold_when_off_R2: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en && !clr) |=> $stable(count_q));

    assert_freerun_step_R9: assert property (@(posedge clk) disable iff (rst)
        (adv && free_run && !clr) |=> (count_q == CNT_W'($past(count_q) + 1'b1)));

    assert_restart_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (adv && !free_run && !clr && count_q == cmp) |=> (count_q == '0));

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int CNT_W      = 32,
    parameter int MAIN_DIV_W = 12,
    parameter int OSC_DIV_W  = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [BUS_W-1:0]      bus_wdata,
    input  logic                  bus_we,
    input  logic                  bus_re,
    output logic [BUS_W-1:0]      bus_rdata,
    input  logic [CNT_W-1:0]      count,
    input  logic                  match_evt,
    output ctrl_t                 ctrl,
    output logic [MAIN_DIV_W-1:0] main_div,
    output logic [OSC_DIV_W-1:0]  osc_div,
    output logic [CNT_W-1:0]      cmp,
    output logic                  soft_clr,
    output logic                  main_restart,
    output logic                  osc_restart
);

    localparam int OSC_LSB = MAIN_DIV_W;

    ctrl_t                 ctrl_q;
    logic [MAIN_DIV_W-1:0] main_q;
    logic [OSC_DIV_W-1:0]  osc_q;
    logic [CNT_W-1:0]      cmp_q;
    logic                  stat_q;
    logic                  swr_q;
    logic [BUS_W-1:0]      rdata_q;
    logic [BUS_W-1:0]      rd_mux;

    logic wr_ctrl, wr_div, wr_stat, wr_cmp, swr_req;
    ctrl_t                 new_ctrl;
    logic [MAIN_DIV_W-1:0] new_main;
    logic [OSC_DIV_W-1:0]  new_osc;

    assign wr_ctrl  = bus_we && (bus_addr == ADDR_W'(OFF_CTRL));
    assign wr_div   = bus_we && (bus_addr == ADDR_W'(OFF_DIV));
    assign wr_stat  = bus_we && (bus_addr == ADDR_W'(OFF_STAT));
    assign wr_cmp   = bus_we && (bus_addr == ADDR_W'(OFF_CMP));
    assign swr_req  = wr_ctrl && bus_wdata[CB_SWR];
    assign new_ctrl = decode_ctrl(bus_wdata);
    assign new_main = bus_wdata[MAIN_DIV_W-1:0];
    assign new_osc  = bus_wdata[OSC_LSB +: OSC_DIV_W];

    assign main_restart = !swr_q && ((wr_ctrl && !swr_req && new_ctrl.src != ctrl_q.src)
                                  || (wr_div && new_main != main_q));
    assign osc_restart  = !swr_q && wr_div && (new_osc != osc_q);

    always_comb begin
        rd_mux = '0;
        if (bus_addr == ADDR_W'(OFF_CTRL)) begin
            rd_mux = encode_ctrl(ctrl_q, swr_q);
        end else if (bus_addr == ADDR_W'(OFF_DIV)) begin
            rd_mux[MAIN_DIV_W-1:0]       = main_q;
            rd_mux[OSC_LSB +: OSC_DIV_W] = osc_q;
        end else if (bus_addr == ADDR_W'(OFF_STAT)) begin
            rd_mux[0] = stat_q;
        end else if (bus_addr == ADDR_W'(OFF_CMP)) begin
            rd_mux = BUS_W'(cmp_q);
        end else if (bus_addr == ADDR_W'(OFF_CNT)) begin
            rd_mux = BUS_W'(count);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || swr_q) begin
            ctrl_q  <= '0;
            main_q  <= '0;
            osc_q   <= '0;
            cmp_q   <= '0;
            stat_q  <= 1'b0;
            swr_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            swr_q <= swr_req;
            if (wr_ctrl && !swr_req) ctrl_q <= new_ctrl;
            if (wr_div) begin
                main_q <= new_main;
                osc_q  <= new_osc;
            end
            if (wr_cmp) cmp_q <= bus_wdata[CNT_W-1:0];
            if (match_evt)                   stat_q <= 1'b1;
            else if (wr_stat && bus_wdata[0]) stat_q <= 1'b0;
            if (bus_re) rdata_q <= rd_mux;
        end
    end

    assign ctrl      = ctrl_q;
    assign main_div  = main_q;
    assign osc_div   = osc_q;
    assign cmp       = cmp_q;
    assign soft_clr  = swr_q;
    assign bus_rdata = rdata_q;

    assert_swr_selfclear_R10: assert property (@(posedge clk) disable iff (rst)
        swr_q |=> !swr_q);

    assert_swr_clears_ctrl_R10: assert property (@(posedge clk) disable iff (rst)
        swr_q |=> (encode_ctrl(ctrl_q, 1'b0) == '0 && main_q == '0 && osc_q == '0));

    assert_match_sets_flag_R7: assert property (@(posedge clk) disable iff (rst)
        (match_evt && !swr_q) |=> stat_q);

endmodule

// File: rtl/gp_tick_timer.sv
module gp_tick_timer
    import tmr_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int CNT_W      = 32,
    parameter int MAIN_DIV_W = 12,
    parameter int OSC_DIV_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [31:0]       bus_rdata,
    input  logic              tick_per,
    input  logic              tick_ref,
    input  logic              tick_osc
);

    ctrl_t                 ctrl;
    logic [MAIN_DIV_W-1:0] main_div;
    logic [OSC_DIV_W-1:0]  osc_div;
    logic [CNT_W-1:0]      cmp;
    logic [CNT_W-1:0]      count;
    logic                  match_evt;
    logic                  soft_clr;
    logic                  main_restart;
    logic                  osc_restart;
    logic                  osc_tick;
    logic                  sel_tick;
    logic                  cnt_tick;

    tmr_regs #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W),
        .MAIN_DIV_W(MAIN_DIV_W), .OSC_DIV_W(OSC_DIV_W)
    ) u_regs (
        .clk(clk), .rst(rst),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .count(count), .match_evt(match_evt),
        .ctrl(ctrl), .main_div(main_div), .osc_div(osc_div), .cmp(cmp),
        .soft_clr(soft_clr), .main_restart(main_restart), .osc_restart(osc_restart)
    );

    tmr_divider #(.W(OSC_DIV_W)) u_osc_div (
        .clk(clk), .rst(rst), .clr(soft_clr), .restart(osc_restart),
        .enable(ctrl.osc_gate), .tick_in(tick_osc), .div(osc_div),
        .tick_out(osc_tick)
    );

    always_comb begin
        case (ctrl.src)
            SRC_PER: sel_tick = tick_per;
            SRC_REF: sel_tick = tick_ref;
            SRC_OSC: sel_tick = osc_tick;
            default: sel_tick = 1'b0;
        endcase
    end

    tmr_divider #(.W(MAIN_DIV_W)) u_main_div (
        .clk(clk), .rst(rst), .clr(soft_clr), .restart(main_restart),
        .enable(ctrl.en), .tick_in(sel_tick), .div(main_div),
        .tick_out(cnt_tick)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_counter (
        .clk(clk), .rst(rst), .clr(soft_clr),
        .cnt_en(ctrl.en), .tick(cnt_tick), .free_run(ctrl.free_run),
        .cmp(cmp), .count(count), .match_evt(match_evt)
    );

endmodule

// File: tb/gp_tick_timer_bench.sv
module gp_tick_timer_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic        tick_per = 1'b0;
    logic        tick_ref = 1'b0;
    logic        tick_osc = 1'b0;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    gp_tick_timer #(.CNT_W(8)) u_gp_tick_timer (
        .clk(clk), .rst(rst),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .tick_per(tick_per), .tick_ref(tick_ref), .tick_osc(tick_osc)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic expect_reg(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    // which: 0 peripheral, 1 reference, 2 oscillator
    task automatic pulse(input int which, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_per = (which == 0); tick_ref = (which == 1); tick_osc = (which == 2);
            @(negedge clk);
            tick_per = 1'b0; tick_ref = 1'b0; tick_osc = 1'b0;
        end
    endtask

    task automatic soft_reset();
        wr(8'h00, 32'h0000_8000);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        expect_reg("R1 ctrl", 8'h00, 0);
        expect_reg("R1 div", 8'h04, 0);
        expect_reg("R1 status", 8'h08, 0);
        expect_reg("R1 compare", 8'h10, 0);
        expect_reg("R1 count", 8'h24, 0);
        expect_reg("R12 unmapped", 8'h0C, 0);
    endtask

    task automatic t_peripheral();
        wr(8'h00, 32'h0000_0241);       // en, src 001, free-run
        pulse(0, 5);
        expect_reg("R3 per count", 8'h24, 5);
        pulse(1, 3);
        expect_reg("R4 unselected ref ignored", 8'h24, 5);
        expect_reg("R12 ctrl readback", 8'h00, 32'h0000_0241);
    endtask

    task automatic t_hold();
        wr(8'h00, 32'h0000_0240);       // enable off
        pulse(0, 4);
        expect_reg("R2 hold", 8'h24, 5);
    endtask

    task automatic t_sources();
        wr(8'h00, 32'h0000_0301);       // src 100
        pulse(1, 3);
        expect_reg("R4 ref count", 8'h24, 8);
        pulse(0, 2);
        expect_reg("R4 per ignored", 8'h24, 8);
        wr(8'h00, 32'h0000_0281);       // reserved code 010
        pulse(0, 2); pulse(1, 2); pulse(2, 2);
        expect_reg("R4 reserved code", 8'h24, 8);
    endtask

    task automatic t_osc();
        wr(8'h00, 32'h0000_0341);       // src 101, gate off
        pulse(2, 4);
        expect_reg("R5 gate off", 8'h24, 8);
        wr(8'h00, 32'h0000_0741);       // gate on
        wr(8'h04, 32'h0000_2000);       // osc divide by 3
        pulse(2, 6);
        expect_reg("R5 osc divided", 8'h24, 10);
    endtask

    task automatic t_swr();
        soft_reset();
        expect_reg("R10 ctrl", 8'h00, 0);
        expect_reg("R10 div", 8'h04, 0);
        expect_reg("R10 count", 8'h24, 0);
        expect_reg("R10 status", 8'h08, 0);
    endtask

    task automatic t_prescale();
        wr(8'h04, 32'h0000_0003);       // main divide by 4
        wr(8'h00, 32'h0000_0241);
        pulse(0, 9);
        expect_reg("R6 main divide", 8'h24, 2);
        wr(8'h04, 32'h0000_0002);       // change to divide by 3: phase restarts
        pulse(0, 2);
        expect_reg("R11 no early tick", 8'h24, 2);
        pulse(0, 1);
        expect_reg("R11 full period", 8'h24, 3);
    endtask

    task automatic t_restart();
        soft_reset();
        wr(8'h10, 32'h0000_0003);
        wr(8'h00, 32'h0000_0041);       // restart mode
        pulse(0, 3);
        expect_reg("R7 count at match", 8'h24, 3);
        expect_reg("R7 flag set", 8'h08, 1);
        pulse(0, 1);
        expect_reg("R8 back to zero", 8'h24, 0);
        wr(8'h08, 32'h0000_0000);
        expect_reg("R7 write 0 keeps flag", 8'h08, 1);
        wr(8'h08, 32'h0000_0001);
        expect_reg("R7 write 1 clears", 8'h08, 0);
        pulse(0, 2);
        expect_reg("R8 counting again", 8'h24, 2);
    endtask

    task automatic t_wrap();
        soft_reset();
        wr(8'h10, 32'h0000_0005);
        wr(8'h00, 32'h0000_0241);       // free-run
        pulse(0, 255);
        expect_reg("R9 passes compare", 8'h24, 32'h0000_00FF);
        expect_reg("R9 flag on pass", 8'h08, 1);
        pulse(0, 1);
        expect_reg("R9 wraps", 8'h24, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_peripheral();
        t_hold();
        t_sources();
        t_osc();
        t_swr();
        t_prescale();
        t_restart();
        t_wrap();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule